// File: doc/BRIEF.md
# Mirrored Memory Channel Manager

This block sits between one client request port and two identical external memory channels, so the client sees a single memory. A protected write is encoded with six single-error-correct, double-error-detect check bits and stored as the same 22-bit word in both channels. A protected read fetches both copies. When they are bit-identical the data goes back at once, with no decode on that path. When they differ, each copy's check bits decide which copy is sound, and the data is repaired from it.

Each channel has a fault input, such as a timeout or a controller error. A fault marks that channel failed until reset. From then on the manager serves every access from the surviving channel and still decodes each protected read. Unprotected accesses are not mirrored. Address bit 0 sends each one to a single channel, which spreads that traffic over both channels. The manager also reports a failed-channel mask, a saturating count of corrected reads and a sticky flag for uncorrectable errors.

Top module: `dup_mem_mgr`

## Requirements
- R1: A protected write sends the same 22-bit word to both channels. Bits 15:0 hold the client data and bits 21:16 hold the check bits.
- R2: On a protected read where both copies match bit for bit, the response carries that data with error code 00 (clean).
- R3: On a protected read where the copies differ and exactly one copy decodes clean, the response carries the clean copy's data with error code 01 (corrected).
- R4: On a protected read where the copies differ, neither copy is clean and at least one has a single-bit error, the response carries the repaired data with code 01. Channel 0 is used when both copies qualify.
- R5: On a protected read where the copies differ and both are uncorrectable, or both decode clean, the response carries error code 10 (uncorrectable).
- R6: A pulse on a channel's fault input marks that channel failed in fail_mask until reset. A failed channel gets no further requests. An access still waiting on that channel completes from the other channel.
- R7: With one channel failed, a protected write goes to the survivor only. A protected read of the survivor is decoded: a single-bit error gives code 01 and a double-bit error gives code 10.
- R8: An unprotected access uses one channel only: channel 0 when address bit 0 is 0, channel 1 when it is 1. If the chosen channel has failed, the access goes to the other channel. Read data is returned raw with code 00 and is not decoded.
- R9: With both channels failed, an access issues no channel request and completes with error code 10.
- R10: req_ready is high only when no request is outstanding. Each accepted request, read or write, gets exactly one single-cycle rsp_valid pulse. A write completes with code 00 while at least one channel took it.
- R11: corr_cnt counts responses with code 01 and saturates at its maximum. uncorr_seen is set by any response with code 10 and stays set until reset.
- R12: During and after reset: req_ready is 1, rsp_valid is 0, ch_req is 0, fail_mask is 0, corr_cnt is 0 and uncorr_seen is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Manager can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prot | input | 1 | 1 = protected (mirrored), 0 = unprotected |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read data |
| rsp_err | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| ch_req | output | 2 | Per-channel request, held until acknowledged |
| ch_we | output | 2 | Per-channel write enable |
| ch_addr | output | 2 x AW | Per-channel address |
| ch_wdata | output | 2 x 22 | Per-channel stored word, {check, data} |
| ch_ack | input | 2 | Per-channel one-cycle acknowledge |
| ch_rdata | input | 2 x 22 | Per-channel read word, valid with ch_ack |
| ch_fault | input | 2 | Per-channel hardware fault indication |
| fail_mask | output | 2 | Latched failed channels |
| corr_cnt | output | CNT_W | Saturating count of corrected responses |
| uncorr_seen | output | 1 | Sticky uncorrectable-error flag |

## Verification
The bench corrupts stored words in its channel models, covering a data bit in one copy, a check bit in one copy, double errors in both copies, and one copy swapped for a different valid codeword. A manager that trusts the copies without decoding would return wrong data under code 00. A manager that decodes only channel 0 would mislabel the case where both copies decode clean but differ. One channel is made to hang until its fault is raised. A manager that does not drop the pending channel would never answer, and the watchdog would catch it. In degraded mode a double-bit error must come back as 10. Unprotected reads of a corrupted word must come back raw, so a manager that decodes them gives itself away by repairing the data.

// File: rtl/dup_pkg.sv
package dup_pkg;
  localparam int DW = 16;
  localparam int KW = 6;
  localparam int WW = DW + KW;

  typedef enum logic [1:0] {EC_CLEAN = 2'b00, EC_FIXED = 2'b01, EC_FATAL = 2'b10} ecode_t;

  typedef struct packed {
    logic [DW-1:0] data;
    ecode_t        code;
  } dec_t;

  // Hamming positions 1..21; powers of two hold parity, the rest hold data
  function automatic logic [WW-1:0] secded_enc(input logic [DW-1:0] d);
    logic [21:0] cw;
    logic [KW-1:0] chk;
    int j;
    cw = '0;
    j = 0;
    for (int p = 1; p < 22; p++)
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[j];
        j++;
      end
    chk = '0;
    for (int k = 0; k < 5; k++)
      for (int p = 1; p < 22; p++)
        if (p[k]) chk[k] = chk[k] ^ cw[p];
    chk[5] = (^d) ^ (^chk[4:0]);
    return {chk, d};
  endfunction

  function automatic dec_t secded_dec(input logic [WW-1:0] w);
    logic [21:0] cw;
    logic [4:0] syn;
    logic ovr;
    dec_t r;
    int j;
    cw = '0;
    j = 0;
    for (int p = 1; p < 22; p++)
      if ((p & (p - 1)) != 0) begin
        cw[p] = w[j];
        j++;
      end
    for (int k = 0; k < 5; k++) cw[1 << k] = w[DW + k];
    syn = '0;
    for (int k = 0; k < 5; k++)
      for (int p = 1; p < 22; p++)
        if (p[k]) syn[k] = syn[k] ^ cw[p];
    ovr = (^cw) ^ w[WW-1];
    r.code = EC_CLEAN;
    if (ovr) begin
      r.code = EC_FIXED;
      if (syn > 5'd21) r.code = EC_FATAL;
      else if (syn != 5'd0) cw[syn] = ~cw[syn];
    end else if (syn != 5'd0) begin
      r.code = EC_FATAL;
    end
    r.data = '0;
    j = 0;
    for (int p = 1; p < 22; p++)
      if ((p & (p - 1)) != 0) begin
        r.data[j] = cw[p];
        j++;
      end
    return r;
  endfunction
endpackage

// File: rtl/dup_health.sv
module dup_health #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] fault,
  output logic [NCH-1:0] failed
);
  always_ff @(posedge clk) begin
    if (rst) failed <= '0;
    else     failed <= failed | fault;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R6
    fault_latch_chk: assert property (@(posedge clk) disable iff (rst)
      fault[g] |=> failed[g]);
  end
endmodule

// File: rtl/dup_secded_dec.sv
module dup_secded_dec
  import dup_pkg::*;
(
  input  logic [WW-1:0] word,
  output logic [DW-1:0] data,
  output ecode_t        code
);
  dec_t r;
  always_comb begin
    r    = secded_dec(word);
    data = r.data;
    code = r.code;
  end
endmodule

// File: rtl/dup_resolve.sv
module dup_resolve
  import dup_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                    prot,
  input  logic [NCH-1:0]          live,
  input  logic [NCH-1:0][WW-1:0]  words,
  output logic [DW-1:0]           data,
  output ecode_t                  code
);
  logic [NCH-1:0][DW-1:0] dd;
  ecode_t dc [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    dup_secded_dec u_dec (.word(words[g]), .data(dd[g]), .code(dc[g]));
  end

  always_comb begin
    data = '0;
    code = EC_FATAL;
    if (!prot) begin
      if (live[0])      begin data = words[0][DW-1:0]; code = EC_CLEAN; end
      else if (live[1]) begin data = words[1][DW-1:0]; code = EC_CLEAN; end
    end else begin
      case (live)
        2'b11: begin
          if (words[0] == words[1]) begin
            data = words[0][DW-1:0]; code = EC_CLEAN;
          end else if (dc[0] == EC_CLEAN && dc[1] != EC_CLEAN) begin
            data = dd[0]; code = EC_FIXED;
          end else if (dc[1] == EC_CLEAN && dc[0] != EC_CLEAN) begin
            data = dd[1]; code = EC_FIXED;
          end else if (dc[0] == EC_FIXED) begin
            data = dd[0]; code = EC_FIXED;
          end else if (dc[1] == EC_FIXED) begin
            data = dd[1]; code = EC_FIXED;
          end else begin
            data = dd[0]; code = EC_FATAL;
          end
        end
        2'b01:   begin data = dd[0]; code = dc[0]; end
        2'b10:   begin data = dd[1]; code = dc[1]; end
        default: begin data = '0;    code = EC_FATAL; end
      endcase
    end
  end
endmodule

// File: rtl/dup_mem_mgr.sv
module dup_mem_mgr
  import dup_pkg::*;
#(
  parameter int AW    = 6,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_prot,
  input  logic [AW-1:0]          req_addr,
  input  logic [15:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_data,
  output logic [1:0]             rsp_err,
  output logic [1:0]             ch_req,
  output logic [1:0]             ch_we,
  output logic [1:0][AW-1:0]     ch_addr,
  output logic [1:0][21:0]       ch_wdata,
  input  logic [1:0]             ch_ack,
  input  logic [1:0][21:0]       ch_rdata,
  input  logic [1:0]             ch_fault,
  output logic [1:0]             fail_mask,
  output logic [CNT_W-1:0]       corr_cnt,
  output logic                   uncorr_seen
);
  localparam int NCH = 2;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic                    wr_q, prot_q, sel, acc;
  logic [AW-1:0]           addr_q;
  logic [WW-1:0]           enc_q;
  logic [NCH-1:0]          tgt_d, tgt_q, got_q, pend, live, failed;
  logic [NCH-1:0][WW-1:0]  rbuf;
  logic [DW-1:0]           res_data, fin_data;
  ecode_t                  res_code, fin_code;

  dup_health #(.NCH(NCH)) u_health (.clk(clk), .rst(rst), .fault(ch_fault), .failed(failed));

  dup_resolve #(.NCH(NCH)) u_resolve (
    .prot(prot_q), .live(live), .words(rbuf), .data(res_data), .code(res_code));

  assign fail_mask = failed;
  assign req_ready = (st == S_IDLE);
  assign acc       = req_valid && req_ready;
  assign sel       = req_addr[0];
  assign pend      = (st == S_WAIT) ? (tgt_q & ~got_q & ~failed) : '0;
  assign live      = tgt_q & got_q & ~failed;
  assign ch_req    = pend;

  always_comb begin
    tgt_d = '0;
    if (req_prot)         tgt_d = ~failed;
    else if (!failed[sel])  tgt_d[sel]  = 1'b1;
    else if (!failed[!sel]) tgt_d[!sel] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_we[i]    = wr_q;
      ch_addr[i]  = addr_q;
      ch_wdata[i] = enc_q;
    end
  end

  always_comb begin
    if (wr_q) begin
      fin_data = '0;
      fin_code = (|live) ? EC_CLEAN : EC_FATAL;
    end else begin
      fin_data = res_data;
      fin_code = res_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      wr_q        <= 1'b0;
      prot_q      <= 1'b0;
      addr_q      <= '0;
      enc_q       <= '0;
      tgt_q       <= '0;
      got_q       <= '0;
      rbuf        <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_err     <= EC_CLEAN;
      corr_cnt    <= '0;
      uncorr_seen <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          st     <= S_WAIT;
          wr_q   <= req_write;
          prot_q <= req_prot;
          addr_q <= req_addr;
          enc_q  <= secded_enc(req_wdata);
          tgt_q  <= tgt_d;
          got_q  <= '0;
        end
        default: begin
          for (int i = 0; i < NCH; i++)
            if (ch_ack[i] && pend[i]) begin
              got_q[i] <= 1'b1;
              rbuf[i]  <= ch_rdata[i];
            end
          if (pend == '0) begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= fin_data;
            rsp_err   <= fin_code;
            if (fin_code == EC_FIXED && corr_cnt != '1) corr_cnt <= corr_cnt + 1'b1;
            if (fin_code == EC_FATAL) uncorr_seen <= 1'b1;
          end
        end
      endcase
    end
  end

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready);
  // R9
  dead_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && (&fail_mask)) |=> (ch_req == '0));
  // R8
  unprot_single_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !prot_q) |-> ($countones(ch_req) <= 1));
  // R6
  failed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_req & fail_mask) == '0);
  // R11
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err == 2'b10) |-> uncorr_seen);
endmodule

// File: tb/test_dup_mem_mgr.sv
module test_dup_mem_mgr;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int CNT_W = 8;
  localparam int LAT [2] = '{1, 3};

  typedef struct packed {
    logic        wr;
    logic        prot;
    logic [5:0]  addr;
    logic [15:0] data;
    logic [21:0] f0;
    logic [21:0] f1;
    logic [1:0]  err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 6'd5,  16'h1234, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b1, 6'd5,  16'h1234, 22'h0,      22'h0,      2'b00},  // R2
    '{1'b1, 1'b1, 6'd6,  16'hBEEF, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b1, 6'd6,  16'hBEEF, 22'h4,      22'h0,      2'b01},  // R3
    '{1'b1, 1'b1, 6'd7,  16'h0F0F, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b1, 6'd7,  16'h0F0F, 22'h0,      22'h3,      2'b01},  // R3
    '{1'b1, 1'b1, 6'd8,  16'h5555, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b1, 6'd8,  16'h5555, 22'h3,      22'h30,     2'b10},  // R5
    '{1'b1, 1'b1, 6'd9,  16'h00FF, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b1, 6'd9,  16'h00FF, 22'h1,      22'h200,    2'b01},  // R4
    '{1'b1, 1'b0, 6'd12, 16'hAAAA, 22'h0,      22'h0,      2'b00},  // R8
    '{1'b1, 1'b0, 6'd13, 16'hBBBB, 22'h0,      22'h0,      2'b00},  // R8
    '{1'b0, 1'b0, 6'd12, 16'hAAAA, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b0, 6'd13, 16'hBBBB, 22'h0,      22'h0,      2'b00},
    '{1'b0, 1'b0, 6'd12, 16'hAAAE, 22'h4,      22'h0,      2'b00},  // R8 raw
    '{1'b0, 1'b1, 6'd10, 16'h0000, 22'h100000, 22'h100000, 2'b00}   // placeholder slot, rewritten below
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_prot = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [1:0] rsp_err, ch_req, ch_we, fail_mask;
  logic [1:0][AW-1:0] ch_addr;
  logic [1:0][21:0] ch_wdata, ch_rdata;
  logic [1:0] ch_ack;
  logic [1:0] flt = 2'b00;
  logic [1:0] dead = 2'b00;
  logic [CNT_W-1:0] corr_cnt;
  logic uncorr_seen;

  logic [21:0] mem [2][64];
  int cnt [2];
  int nvec = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  dup_mem_mgr #(.AW(AW), .CNT_W(CNT_W)) i_dup_mem_mgr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_prot(req_prot), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .ch_req(ch_req), .ch_we(ch_we), .ch_addr(ch_addr),
    .ch_wdata(ch_wdata), .ch_ack(ch_ack), .ch_rdata(ch_rdata),
    .ch_fault(flt), .fail_mask(fail_mask), .corr_cnt(corr_cnt),
    .uncorr_seen(uncorr_seen));

  // channel models: fixed latency, one-cycle acknowledge
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        ch_ack[i] <= 1'b0;
        cnt[i] <= 0;
        ch_rdata[i] <= '0;
        for (int j = 0; j < 64; j++) mem[i][j] <= '0;
      end else if (ch_ack[i]) begin
        ch_ack[i] <= 1'b0;
        cnt[i] <= 0;
      end else if (ch_req[i] && !dead[i]) begin
        if (cnt[i] == LAT[i]) begin
          ch_ack[i] <= 1'b1;
          if (ch_we[i]) mem[i][ch_addr[i]] <= ch_wdata[i];
          else          ch_rdata[i] <= mem[i][ch_addr[i]];
        end else begin
          cnt[i] <= cnt[i] + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic prot, input logic [5:0] a,
                        input logic [15:0] wd, output logic [15:0] rd, output logic [1:0] er);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_prot = prot; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    rd = '0; er = 2'b11;
    while (n < 100) begin
      @(negedge clk);
      if (rsp_valid) begin
        rd = rsp_data; er = rsp_err;
        n = 1000;
      end
      n++;
    end
    if (n < 1000) chk("R10 response arrived", 32'd0, 32'd1);
  endtask

  task automatic flip(input logic [5:0] a, input logic [21:0] m0, input logic [21:0] m1);
    @(negedge clk);
    mem[0][a] <= mem[0][a] ^ m0;
    mem[1][a] <= mem[1][a] ^ m1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [1:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 ch_req", {30'd0, ch_req}, 32'd0);
    chk("R12 fail_mask", {30'd0, fail_mask}, 32'd0);
    chk("R12 corr_cnt", {24'd0, corr_cnt}, 32'd0);
    chk("R12 uncorr_seen", {31'd0, uncorr_seen}, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NV - 1; v++) begin
      if (VEC[v].f0 != '0 || VEC[v].f1 != '0) flip(VEC[v].addr, VEC[v].f0, VEC[v].f1);
      access(VEC[v].wr, VEC[v].prot, VEC[v].addr, VEC[v].data, d, e);
      if (VEC[v].wr) begin
        chk("R10 write code", {30'd0, e}, 32'd0);
        if (VEC[v].prot) begin
          chk("R1 copies equal", {10'd0, mem[0][VEC[v].addr]}, {10'd0, mem[1][VEC[v].addr]});
          chk("R1 data field", {16'd0, mem[0][VEC[v].addr][15:0]}, {16'd0, VEC[v].data});
        end else begin
          chk("R8 chosen channel", {16'd0, mem[VEC[v].addr[0]][VEC[v].addr][15:0]}, {16'd0, VEC[v].data});
          chk("R8 other untouched", {10'd0, mem[!VEC[v].addr[0]][VEC[v].addr]}, 32'd0);
        end
      end else begin
        chk("R2/R3/R4/R5/R8 code", {30'd0, e}, {30'd0, VEC[v].err});
        if (VEC[v].err != 2'b10) chk("R2/R3/R4/R8 data", {16'd0, d}, {16'd0, VEC[v].data});
      end
    end

    // R3: corrupt a check bit in copy 1
    access(1'b1, 1'b1, 6'd10, 16'hF00D, d, e);
    flip(6'd10, 22'h0, 22'h100000);
    access(1'b0, 1'b1, 6'd10, 16'h0, d, e);
    chk("R3 check-bit code", {30'd0, e}, 32'd1);
    chk("R3 check-bit data", {16'd0, d}, 32'h0000F00D);

    // R5: both copies valid codewords but different
    access(1'b1, 1'b1, 6'd11, 16'h7777, d, e);
    @(negedge clk);
    mem[0][11] <= mem[0][5];
    @(negedge clk);
    access(1'b0, 1'b1, 6'd11, 16'h0, d, e);
    chk("R5 clean-but-different code", {30'd0, e}, 32'd2);
    chk("R11 sticky set", {31'd0, uncorr_seen}, 32'd1);

    // R6: channel 0 hangs, fault raised while the read waits
    dead[0] = 1'b1;
    fork
      access(1'b0, 1'b1, 6'd5, 16'h0, d, e);
      begin
        repeat (12) @(negedge clk);
        flt[0] = 1'b1;
        @(negedge clk);
        flt[0] = 1'b0;
      end
    join
    chk("R6 pending completes code", {30'd0, e}, 32'd0);
    chk("R6 pending completes data", {16'd0, d}, 32'h00001234);
    repeat (3) @(negedge clk);
    chk("R6 fail latched", {30'd0, fail_mask}, 32'd1);
    chk("R6 no request to failed", {30'd0, ch_req}, 32'd0);

    // R7: degraded mode on channel 1
    access(1'b1, 1'b1, 6'd20, 16'hCAFE, d, e);
    chk("R7 survivor written", {16'd0, mem[1][20][15:0]}, 32'h0000CAFE);
    chk("R7 failed not written", {10'd0, mem[0][20]}, 32'd0);
    flip(6'd20, 22'h0, 22'h20);
    access(1'b0, 1'b1, 6'd20, 16'h0, d, e);
    chk("R7 single corrected code", {30'd0, e}, 32'd1);
    chk("R7 single corrected data", {16'd0, d}, 32'h0000CAFE);
    flip(6'd20, 22'h0, 22'h40);
    access(1'b0, 1'b1, 6'd20, 16'h0, d, e);
    chk("R7 double detected", {30'd0, e}, 32'd2);

    // R8: unprotected access to failed channel 0 redirected to channel 1
    access(1'b0, 1'b0, 6'd12, 16'h0, d, e);
    chk("R8 redirect code", {30'd0, e}, 32'd0);
    chk("R8 redirect data", {16'd0, d}, 32'd0);
    chk("R11 corr_cnt", {24'd0, corr_cnt}, 32'd5);

    // R9: both channels failed
    @(negedge clk);
    flt[1] = 1'b1;
    @(negedge clk);
    flt[1] = 1'b0;
    chk("R6 both failed", {30'd0, fail_mask}, 32'd3);
    access(1'b0, 1'b1, 6'd5, 16'h0, d, e);
    chk("R9 no channel code", {30'd0, e}, 32'd2);

    // R6/R11/R12: reset clears latched state
    dead = 2'b00;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 reset clears fail", {30'd0, fail_mask}, 32'd0);
    chk("R11 reset clears count", {24'd0, corr_cnt}, 32'd0);
    chk("R11 reset clears sticky", {31'd0, uncorr_seen}, 32'd0);
    rst = 1'b0;
    access(1'b1, 1'b1, 6'd3, 16'h9A9A, d, e);
    access(1'b0, 1'b1, 6'd3, 16'h0, d, e);
    chk("R2 after reset code", {30'd0, e}, 32'd0);
    chk("R2 after reset data", {16'd0, d}, 32'h00009A9A);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule